// File: doc/BRIEF.md
# Receive Frame Admission Controller

This block judges each incoming Ethernet frame before any byte of it reaches memory. For every frame it is offered, it is given the frame length, the address-filter verdict and the hardware-ownership bit of the current receive descriptor. It then runs a fixed sequence of checks. The outcome, registered one cycle later, is a store/drop decision, the number of bytes the memory mover must write, a flag that tells the mover to append the four CRC bytes, a set of one-cycle event pulses for the interrupt status logic, and the status word to write back into the descriptor.

The checks always run in the same order. First the length is checked for a legal range. Then an event marks that the length/type field has arrived. After that come the filter verdict, the programmed maximum receive size, the standard long-frame limit and descriptor ownership. Only the first failing check raises its own event. When the descriptor is still held by software, reception halts: frames offered while halted are ignored until a resume pulse. CRC computation and the memory transfer belong to neighbouring units.

Top module: `rx_admit`

## Requirements
- R1: After reset no result is presented (`res_valid` low), `rx_halted` is low and the programmed maximum receive size is 2048 bytes.
- R2: A frame shorter than 14 bytes, or whose length plus 4 exceeds 65535, gives a result with `res_store` low, `res_evt` all zero and `res_status` zero.
- R3: Every frame that passes R2 raises `res_evt[0]` (length/type seen) in its result, whatever the later checks decide.
- R4: A frame rejected by the filter (`filt_pass` low) is dropped, with only `res_evt[0]` raised.
- R5: A frame whose length plus 4 exceeds the programmed maximum is dropped and raises `res_evt[1]`. A length plus 4 equal to the maximum passes. A `maxsz_we` pulse loads `maxsz_wdata` as the new maximum.
- R6: A frame whose length plus 4 exceeds 1518 while `accept_long` is low is dropped and raises `res_evt[2]`. A length of 1514 passes.
- R7: With `accept_long` high, such a long frame is stored and `res_status[18]` is set.
- R8: If `desc_own` is low, the frame is dropped, `res_evt[3]` is raised and `rx_halted` goes high. Later frames give no result until a `resume` pulse clears the halt.
- R9: For a stored frame with `strip_crc` low, `res_bytes` is the length plus 4 and `res_crc_app` is high. With `strip_crc` high, `res_bytes` is the length and `res_crc_app` is low.
- R10: For a stored frame, `res_status[15:0]` equals `res_bytes`, `res_status[16]` (receive good) is set, `res_status[31]` (owner) is clear and `res_evt[4]` is raised. A dropped frame gives `res_bytes` zero.
- R11: For a stored frame, `res_status[17]` equals `irq_active` OR `rxgd_irq_en`.
- R12: Checks run in the order R2, filter, R5, R6, R8. At most one of `res_evt[4:1]` is raised per frame, namely the one for the first failing check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle pulse presenting a frame for judgement |
| frm_len | input | 16 | Frame length in bytes, without CRC |
| filt_pass | input | 1 | Address filter accepted the frame |
| desc_own | input | 1 | Current descriptor is owned by hardware |
| accept_long | input | 1 | Keep frames longer than the standard limit |
| strip_crc | input | 1 | Do not store the CRC bytes |
| irq_active | input | 1 | Receive summary interrupt already active and enabled |
| rxgd_irq_en | input | 1 | Receive-good interrupt enable |
| maxsz_we | input | 1 | Load a new maximum receive size |
| maxsz_wdata | input | 16 | New maximum receive size |
| resume | input | 1 | Clear the halted state |
| res_valid | output | 1 | Result for a frame presented in the previous cycle |
| res_store | output | 1 | Frame is to be written to memory |
| res_bytes | output | 16 | Bytes to write, CRC included when appended |
| res_crc_app | output | 1 | Append the 4 CRC bytes, most significant first |
| res_evt | output | 5 | Event pulses: 0 len/type, 1 oversize, 2 too long, 3 no descriptor, 4 good |
| res_status | output | 32 | Descriptor status word to write back |
| rx_halted | output | 1 | Reception halted for lack of a descriptor |

## Verification
If the halt flag is stuck in the wrong state, either frames vanish with no result or a frame still produces a result after a descriptor miss. Either shows up in the cycle after the next offered frame. If the stored maximum size is wrong, a frame near 2048 bytes, or near a newly loaded maximum, gets the wrong verdict in its first result. Wrong check ordering shows as two event bits at once, or as the wrong one, in the result of a frame that fails two checks.

// File: rtl/rx_admit.sv
module rx_admit #(
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 14,
  parameter int STD_MAX   = 1518,
  parameter int CRC_BYTES = 4,
  parameter int MAXSZ_RST = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             filt_pass,
  input  logic             desc_own,
  input  logic             accept_long,
  input  logic             strip_crc,
  input  logic             irq_active,
  input  logic             rxgd_irq_en,
  input  logic             maxsz_we,
  input  logic [LEN_W-1:0] maxsz_wdata,
  input  logic             resume,
  output logic             res_valid,
  output logic             res_store,
  output logic [LEN_W-1:0] res_bytes,
  output logic             res_crc_app,
  output logic [4:0]       res_evt,
  output logic [31:0]      res_status,
  output logic             rx_halted
);
  localparam int SUM_W   = LEN_W + 1;
  localparam int LEN_LIM = (1 << LEN_W) - 1;
  localparam int EV_LT = 0, EV_OVR = 1, EV_LONG = 2, EV_NODESC = 3, EV_GOOD = 4;
  localparam int ST_GOOD = 16, ST_INTR = 17, ST_LONG = 18, ST_OWN = 31;

  logic [LEN_W-1:0] max_q;
  logic             halt_q;

  wire [SUM_W-1:0] len_crc = {1'b0, frm_len} + SUM_W'(CRC_BYTES);
  wire take    = frm_valid && !halt_q;
  wire bad_len = (frm_len < LEN_W'(MIN_LEN)) || (len_crc > SUM_W'(LEN_LIM));
  wire over    = len_crc > {1'b0, max_q};
  wire longf   = len_crc > SUM_W'(STD_MAX);

  logic             n_store, n_halt, n_crc;
  logic [4:0]       n_evt;
  logic [LEN_W-1:0] n_bytes;
  logic [31:0]      n_status;

  always_comb begin
    n_store  = 1'b0;
    n_halt   = 1'b0;
    n_crc    = 1'b0;
    n_evt    = '0;
    n_bytes  = '0;
    n_status = '0;
    if (!bad_len) begin
      n_evt[EV_LT] = 1'b1;
      if (!filt_pass) begin
        n_evt = n_evt;
      end else if (over) begin
        n_evt[EV_OVR] = 1'b1;
      end else if (longf && !accept_long) begin
        n_evt[EV_LONG] = 1'b1;
      end else if (!desc_own) begin
        n_evt[EV_NODESC] = 1'b1;
        n_halt = 1'b1;
      end else begin
        n_store = 1'b1;
        n_crc   = !strip_crc;
        n_bytes = strip_crc ? frm_len : len_crc[LEN_W-1:0];
        n_evt[EV_GOOD] = 1'b1;
        n_status[LEN_W-1:0] = n_bytes;
        n_status[ST_GOOD]   = 1'b1;
        n_status[ST_INTR]   = irq_active || rxgd_irq_en;
        n_status[ST_LONG]   = longf;
        n_status[ST_OWN]    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q       <= LEN_W'(MAXSZ_RST);
      halt_q      <= 1'b0;
      res_valid   <= 1'b0;
      res_store   <= 1'b0;
      res_bytes   <= '0;
      res_crc_app <= 1'b0;
      res_evt     <= '0;
      res_status  <= '0;
    end else begin
      if (maxsz_we) max_q <= maxsz_wdata;
      if (take && n_halt) halt_q <= 1'b1;
      else if (resume)    halt_q <= 1'b0;
      res_valid   <= take;
      res_store   <= take && n_store;
      res_bytes   <= take ? n_bytes : '0;
      res_crc_app <= take && n_crc;
      res_evt     <= take ? n_evt : '0;
      res_status  <= take ? n_status : '0;
    end
  end

  assign rx_halted = halt_q;
endmodule

// File: rtl/rx_admit_chk.sv
module rx_admit_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             resume,
  input logic             res_valid,
  input logic             res_store,
  input logic [LEN_W-1:0] res_bytes,
  input logic             res_crc_app,
  input logic [4:0]       res_evt,
  input logic [31:0]      res_status,
  input logic             rx_halted
);
  assert_one_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_evt[4:1]));

  assert_no_result_when_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && rx_halted) |=> !res_valid);

  assert_halt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_halted) |-> (res_evt[3] && res_valid && !res_store));

  assert_store_events_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_store |-> (res_evt[0] && res_evt[4] && res_status[16] && !res_status[31]));

  assert_status_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_store |-> (res_status[LEN_W-1:0] == res_bytes));

  assert_drop_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_store) |-> (res_bytes == '0 && !res_crc_app && res_status == '0));

  assert_lt_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_evt[4:1] != '0) |-> res_evt[0]);

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_evt == '0 && !res_store));
endmodule

bind rx_admit rx_admit_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .resume(resume),
  .res_valid(res_valid), .res_store(res_store), .res_bytes(res_bytes),
  .res_crc_app(res_crc_app), .res_evt(res_evt), .res_status(res_status),
  .rx_halted(rx_halted)
);

// File: tb/rx_admit_tb_top.sv
module rx_admit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 0, filt_pass = 0, desc_own = 0, accept_long = 0;
  logic        strip_crc = 0, irq_active = 0, rxgd_irq_en = 0, maxsz_we = 0, resume = 0;
  logic [15:0] frm_len = 0, maxsz_wdata = 0;
  logic        res_valid, res_store, res_crc_app, rx_halted;
  logic [15:0] res_bytes;
  logic [4:0]  res_evt;
  logic [31:0] res_status;

  always #10 clk = ~clk;

  rx_admit dut_i (.*);

  typedef struct packed {
    logic        store;
    logic [15:0] bytes;
    logic        crc;
    logic [4:0]  evt;
    logic [31:0] status;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  int mdl_max = 2048;
  bit mdl_halt = 0;

  function automatic exp_t model(int len, bit fp, bit own, bit al, bit sc, bit ia, bit en);
    exp_t e = '0;
    if (len < 14 || len + 4 > 65535) return e;
    e.evt[0] = 1;
    if (!fp) return e;
    if (len + 4 > mdl_max) begin e.evt[1] = 1; return e; end
    if (len + 4 > 1518 && !al) begin e.evt[2] = 1; return e; end
    if (!own) begin e.evt[3] = 1; return e; end
    e.store = 1;
    e.crc = !sc;
    e.bytes = 16'(sc ? len : len + 4);
    e.evt[4] = 1;
    e.status[15:0] = e.bytes;
    e.status[16] = 1;
    e.status[17] = ia | en;
    e.status[18] = (len + 4 > 1518);
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic send(string req, int len, bit fp, bit own, bit al, bit sc, bit ia, bit en);
    exp_t e;
    @(negedge clk);
    frm_len = 16'(len); filt_pass = fp; desc_own = own; accept_long = al;
    strip_crc = sc; irq_active = ia; rxgd_irq_en = en; frm_valid = 1;
    if (!mdl_halt) begin
      e = model(len, fp, own, al, sc, ia, en);
      exp_q.push_back(e);
      tag_q.push_back(req);
      if (e.evt[3]) mdl_halt = 1;
    end
    @(negedge clk);
    frm_valid = 0;
    @(negedge clk);
  endtask

  task automatic set_max(int v);
    @(negedge clk);
    maxsz_we = 1; maxsz_wdata = 16'(v);
    @(negedge clk);
    maxsz_we = 0;
    mdl_max = v;
  endtask

  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(posedge clk); #2;
      if (rst_n && res_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected result", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_store == e.store, t, "store", res_store, e.store);
          check(res_bytes == e.bytes, t, "bytes", res_bytes, e.bytes);
          check(res_crc_app == e.crc, t, "crc_app", res_crc_app, e.crc);
          check(res_evt == e.evt, t, "events", res_evt, e.evt);
          check(res_status == e.status, t, "status", res_status, e.status);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #5;
    check(res_valid == 0, "R1", "valid at reset", res_valid, 0);
    check(rx_halted == 0, "R1", "halted at reset", rx_halted, 0);
    rst_n = 1;
    // R9 R10 normal frames
    send("R9", 64, 1, 1, 0, 0, 0, 0);
    send("R9", 100, 1, 1, 0, 1, 0, 0);
    // R11 interrupt flag
    send("R11", 60, 1, 1, 0, 0, 0, 1);
    send("R11", 60, 1, 1, 0, 0, 1, 0);
    // R2 length range
    send("R2", 13, 1, 1, 0, 0, 0, 0);
    send("R2", 14, 1, 1, 0, 0, 0, 0);
    send("R2", 65532, 1, 1, 1, 0, 0, 0);
    // R4 filter
    send("R4", 200, 0, 1, 0, 0, 0, 0);
    // R1 R5 default maximum 2048
    send("R5", 2044, 1, 1, 1, 0, 0, 0);
    send("R5", 2045, 1, 1, 1, 0, 0, 0);
    // R6 R7 long frames
    send("R6", 1514, 1, 1, 0, 0, 0, 0);
    send("R6", 1515, 1, 1, 0, 0, 0, 0);
    send("R7", 1600, 1, 1, 1, 1, 0, 0);
    // R12 ordering
    send("R12", 3000, 0, 0, 0, 0, 0, 0);
    send("R12", 3000, 1, 0, 0, 0, 0, 0);
    send("R12", 1600, 1, 0, 0, 0, 0, 0);
    // R5 programmed maximum
    set_max(100);
    send("R5", 96, 1, 1, 0, 0, 0, 0);
    send("R5", 97, 1, 1, 0, 0, 0, 0);
    set_max(65535);
    send("R2", 65531, 1, 1, 1, 0, 0, 0);
    // R8 halt and resume
    send("R8", 80, 1, 0, 0, 0, 0, 0);
    check(rx_halted == 1, "R8", "halted after miss", rx_halted, 1);
    send("R8", 80, 1, 1, 0, 0, 0, 0);
    check(rx_halted == 1, "R8", "still halted", rx_halted, 1);
    @(negedge clk); resume = 1; @(negedge clk); resume = 0; mdl_halt = 0;
    check(rx_halted == 0, "R8", "resumed", rx_halted, 0);
    send("R8", 80, 1, 1, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8", "missing results", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule